// File: doc/BRIEF.md
# Phase-Resuming Sinusoidal PWM Generator

This block drives the two switch pairs of a full-bridge inverter with bipolar sinusoidal PWM. The switching period is fixed. Within each period the block sends one pulse at most, whose width follows a stored quarter-wave sine. One output enables the switch pair for the positive half-cycle and the other enables the pair for the negative half-cycle. A sine cycle has 4·QTR_N switching periods. With the defaults this is about 10 pulses per quarter cycle, which gives a 60 Hz class waveform at a 2.5 kHz switching rate.

While the mains is present, a zero-crossing input restarts an internal phase timer on each of its edges. The input is high during the negative half-cycle of the mains and low during the positive half. When the controller raises the enable after an outage, the block does not start at phase zero. It takes the half-cycle polarity from the level of the zero-crossing input. It takes the step within that half from the time elapsed since the last edge, at one step per switching period. The backup waveform therefore picks up near the phase the line had reached.

While the block runs, a signed trim input lets a controller slew the phase by one step per sine cycle. This is used to bring the inverter back into line with a restored mains before the load is transferred back.

Top module: `phase_resume_spwm`

## Requirements
- R1: While reset is low, and on the first cycle after reset, both gate outputs are low.
- R2: The switching period is 2^DUTY_W·TICK_DIV clocks. The pulse of a period is high from the first clock of that period for duty·TICK_DIV clocks, then low for the rest of the period.
- R3: The duty for quarter index q is floor((2^DUTY_W−1)·16a/(5P²−4a)), where x=2q+1, P=4·QTR_N and a=x(P−x). Step j of a half-cycle (0..2·QTR_N−1) uses q=j for j<QTR_N and q=2·QTR_N−1−j otherwise.
- R4: Steps of the positive half pulse only `gate_pos_o`, and steps of the negative half pulse only `gate_neg_o`. The two outputs are never high in the same cycle.
- R5: Each rising edge and each falling edge of `zc_i` restarts the phase timer. Between edges the timer counts clocks and stops at its ceiling.
- R6: The first period after enable uses step min(timer / (2^DUTY_W·TICK_DIV), 2·QTR_N−1). It is in the negative half when `zc_i` is 1 and in the positive half when it is 0.
- R7: The step advances by one at each period boundary. After step 2·QTR_N−1 the polarity flips and the step returns to 0.
- R8: A new duty value takes effect only at a period boundary. Zero-crossing edges and trim changes during a run leave the width of the current pulse unchanged.
- R9: If `trim_i` is +1 (2'b01) at the end of a negative half, the next positive half starts at step 1 instead of step 0.
- R10: If `trim_i` is −1 (2'b11) at the end of a negative half, the last negative step repeats once and the positive half then starts at step 0. A trim of 0 leaves the sequence unchanged.
- R11: One clock after `en_i` goes low, both gates are low. A later enable takes its start point again by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run the inverter while high |
| zc_i | input | 1 | Mains zero-crossing level, high in the negative half, synchronous to clk |
| trim_i | input | 2 | Signed phase trim: 01 advance, 11 retard, 00 none |
| gate_pos_o | output | 1 | Enable for the positive half-cycle switch pair |
| gate_neg_o | output | 1 | Enable for the negative half-cycle switch pair |

## Verification
The bench builds the block with DUTY_W=6, QTR_N=4 and TICK_DIV=1. A switching period is then 64 clocks and a sine cycle is 16 periods. A full cycle, the wrap where the trim acts, and the point where the phase timer saturates can all be reached in a few thousand clocks. The bench measures the pulse width of each period at the pins and compares it with the closed-form duty. This way it checks the mirrored quarter-wave order, the start step chosen from elapsed time after either zero-crossing edge, and the one-step advance or repeat set by the trim.

// File: rtl/spwm_pkg.sv
// Shared helpers for the phase-resuming sinusoidal PWM generator.
// Assumes: quarter tables are small enough for 64-bit integer arithmetic.
package spwm_pkg;

    // Rational sine approximation for the centre of quarter slot k of n,
    // scaled to the full code range of a w-bit duty value.
    function automatic longint unsigned sine_code(input int unsigned k,
                                                  input int unsigned n,
                                                  input int unsigned w);
        longint unsigned x, p, a, num, den;
        x   = 2 * longint'(k) + 1;
        p   = 4 * longint'(n);
        a   = x * (p - x);
        num = 16 * a;
        den = 5 * p * p - 4 * a;
        return (((longint'(1) << w) - 1) * num) / den;
    endfunction

endpackage

// File: rtl/spwm_zc_timer.sv
// Phase timer: restarts on every zero-crossing edge, counts clocks since the
// last edge with saturation, and turns the count into a half-cycle step.
// Assumes: zc_i is already synchronous to clk.
module spwm_zc_timer #(
    parameter int STEP_CLKS = 64,
    parameter int HSTEPS    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          zc_i,
    output logic [$clog2(HSTEPS)-1:0]     start_j_o
);
    localparam int TMAX = HSTEPS * STEP_CLKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int JW   = $clog2(HSTEPS);

    logic          zc_q;
    logic [TW-1:0] timer_q;
    logic          edge_w;
    logic [TW-1:0] quot_w;

    assign edge_w = zc_i ^ zc_q;

    // Track the previous zero-crossing level and the elapsed time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_q    <= 1'b0;
            timer_q <= '0;
        end else begin
            zc_q <= zc_i;
            if (edge_w)
                timer_q <= '0;
            else if (timer_q != TW'(TMAX))
                timer_q <= timer_q + 1'b1;
        end
    end

    // Map elapsed time to a step, clamped to the last step of a half.
    always_comb begin
        quot_w = timer_q / TW'(STEP_CLKS);
        if (quot_w >= TW'(HSTEPS))
            start_j_o = JW'(HSTEPS - 1);
        else
            start_j_o = JW'(quot_w);
    end

    p_zc_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w |=> (timer_q == '0));

    p_timer_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q <= TW'(TMAX));

    p_start_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_j_o < JW'(HSTEPS - 1) || start_j_o == JW'(HSTEPS - 1));

endmodule

// File: rtl/spwm_sine_rom.sv
// Quarter-wave sine table, filled at elaboration from the package formula.
// Assumes: QTR_N >= 2.
module spwm_sine_rom #(
    parameter int DUTY_W = 10,
    parameter int QTR_N  = 10
) (
    input  logic [$clog2(QTR_N)-1:0] addr_i,
    output logic [DUTY_W-1:0]        duty_o
);
    logic [DUTY_W-1:0] tab_w [QTR_N];

    // One constant entry per quarter slot.
    for (genvar k = 0; k < QTR_N; k++) begin : g_tab
        assign tab_w[k] = DUTY_W'(spwm_pkg::sine_code(k, QTR_N, DUTY_W));
    end

    assign duty_o = tab_w[addr_i];

endmodule

// File: rtl/spwm_stepper.sv
// Switching-period sawtooth, half-cycle step sequencer with trim, and the
// duty register that loads only at period boundaries.
// Assumes: QTR_N >= 2, TICK_DIV >= 1.
module spwm_stepper #(
    parameter int DUTY_W   = 10,
    parameter int QTR_N    = 10,
    parameter int TICK_DIV = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic                          zc_i,
    input  logic [1:0]                    trim_i,
    input  logic [$clog2(2*QTR_N)-1:0]    start_j_i,
    input  logic [DUTY_W-1:0]             duty_i,
    output logic [$clog2(QTR_N)-1:0]      addr_o,
    output logic                          active_o,
    output logic                          neg_o,
    output logic [DUTY_W-1:0]             cnt_o,
    output logic [DUTY_W-1:0]             duty_o
);
    localparam int HSTEPS = 2 * QTR_N;
    localparam int JW     = $clog2(HSTEPS);
    localparam int QAW    = $clog2(QTR_N);
    localparam int TKW    = $clog2(TICK_DIV + 1);
    localparam logic [DUTY_W-1:0] CNT_LAST = '1;
    localparam logic [JW-1:0]     J_LAST   = JW'(HSTEPS - 1);

    logic              active_q, neg_q, held_q;
    logic [JW-1:0]     j_q;
    logic [DUTY_W-1:0] cnt_q, duty_q;
    logic [TKW-1:0]    tick_q;

    logic              tick_w, pend_w, adv_w, ret_w;
    logic              neg_n, held_n;
    logic [JW-1:0]     j_n;

    assign tick_w = (tick_q == TKW'(TICK_DIV - 1));
    assign pend_w = active_q && tick_w && (cnt_q == CNT_LAST);
    assign adv_w  = !trim_i[1] && trim_i[0];
    assign ret_w  = trim_i[1];

    // Choose the step and polarity for the coming period.
    always_comb begin
        j_n    = j_q;
        neg_n  = neg_q;
        held_n = held_q;
        if (!active_q) begin
            j_n    = start_j_i;
            neg_n  = zc_i;
            held_n = 1'b0;
        end else if (pend_w) begin
            if (j_q == J_LAST) begin
                if (!neg_q) begin
                    neg_n = 1'b1;
                    j_n   = '0;
                end else if (ret_w && !held_q) begin
                    held_n = 1'b1;
                end else begin
                    neg_n  = 1'b0;
                    held_n = 1'b0;
                    j_n    = adv_w ? JW'(1) : '0;
                end
            end else begin
                j_n = j_q + 1'b1;
            end
        end
    end

    // Mirror the half-cycle step onto the quarter table.
    always_comb begin
        if (j_n < JW'(QTR_N))
            addr_o = QAW'(j_n);
        else
            addr_o = QAW'(J_LAST - j_n);
    end

    // Run state, sawtooth and duty register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            neg_q    <= 1'b0;
            held_q   <= 1'b0;
            j_q      <= '0;
            cnt_q    <= '0;
            tick_q   <= '0;
            duty_q   <= '0;
        end else if (!en_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            tick_q   <= '0;
        end else begin
            active_q <= 1'b1;
            if (!active_q) begin
                cnt_q  <= '0;
                tick_q <= '0;
                j_q    <= j_n;
                neg_q  <= neg_n;
                held_q <= held_n;
                duty_q <= duty_i;
            end else begin
                tick_q <= tick_w ? '0 : tick_q + 1'b1;
                if (tick_w)
                    cnt_q <= cnt_q + 1'b1;
                if (pend_w) begin
                    j_q    <= j_n;
                    neg_q  <= neg_n;
                    held_q <= held_n;
                    duty_q <= duty_i;
                end
            end
        end
    end

    assign active_o = active_q;
    assign neg_o    = neg_q;
    assign cnt_o    = cnt_q;
    assign duty_o   = duty_q;

    p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !pend_w) |=> $stable(duty_q));

    p_step_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && en_i && j_q != J_LAST) |=> (j_q == JW'($past(j_q) + 1'b1)));

    p_half_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && en_i && j_q == J_LAST && !neg_q) |=> (neg_q && j_q == '0));

    p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        j_q <= J_LAST);

endmodule

// File: rtl/phase_resume_spwm.sv
// Top: sinusoidal PWM gate commands for a full-bridge inverter that resume
// at the mains phase estimated from the last zero crossing.
// Assumes: zc_i and trim_i are synchronous to clk; dead time is added later.
module phase_resume_spwm #(
    parameter int DUTY_W   = 10,
    parameter int QTR_N    = 10,
    parameter int TICK_DIV = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       zc_i,
    input  logic [1:0] trim_i,
    output logic       gate_pos_o,
    output logic       gate_neg_o
);
    localparam int HSTEPS    = 2 * QTR_N;
    localparam int STEP_CLKS = (1 << DUTY_W) * TICK_DIV;
    localparam int JW        = $clog2(HSTEPS);
    localparam int QAW       = $clog2(QTR_N);

    logic [JW-1:0]     start_j_w;
    logic [QAW-1:0]    addr_w;
    logic [DUTY_W-1:0] rom_duty_w, duty_w, cnt_w;
    logic              active_w, neg_w, on_w;

    spwm_zc_timer #(
        .STEP_CLKS (STEP_CLKS),
        .HSTEPS    (HSTEPS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_i      (zc_i),
        .start_j_o (start_j_w)
    );

    spwm_sine_rom #(
        .DUTY_W (DUTY_W),
        .QTR_N  (QTR_N)
    ) i_rom (
        .addr_i (addr_w),
        .duty_o (rom_duty_w)
    );

    spwm_stepper #(
        .DUTY_W   (DUTY_W),
        .QTR_N    (QTR_N),
        .TICK_DIV (TICK_DIV)
    ) i_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .zc_i      (zc_i),
        .trim_i    (trim_i),
        .start_j_i (start_j_w),
        .duty_i    (rom_duty_w),
        .addr_o    (addr_w),
        .active_o  (active_w),
        .neg_o     (neg_w),
        .cnt_o     (cnt_w),
        .duty_o    (duty_w)
    );

    // Comparator: pulse from sawtooth restart until it reaches the duty.
    always_comb begin
        on_w       = active_w && (cnt_w < duty_w);
        gate_pos_o = on_w && !neg_w;
        gate_neg_o = on_w && neg_w;
    end

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_pos_o && gate_neg_o));

    p_idle_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!gate_pos_o && !gate_neg_o));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!gate_pos_o && !gate_neg_o));

endmodule

// File: tb/test_phase_resume_spwm.sv
module test_phase_resume_spwm;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 6;
    localparam int QN   = 4;
    localparam int PER  = 1 << DW;
    localparam int HS   = 2 * QN;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       zc = 1'b0;
    logic [1:0] trim = 2'b00;
    logic       gp, gn;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_resume_spwm #(.DUTY_W(DW), .QTR_N(QN), .TICK_DIV(1)) i_phase_resume_spwm (
        .clk(clk), .rst_n(rst_n), .en_i(en), .zc_i(zc), .trim_i(trim),
        .gate_pos_o(gp), .gate_neg_o(gn)
    );

    function automatic int exp_duty(input int j);
        int q, x, p, a;
        q = (j < QN) ? j : (HS - 1 - j);
        x = 2 * q + 1;
        p = 4 * QN;
        a = x * (p - x);
        return ((PER - 1) * 16 * a) / (5 * p * p - 4 * a);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count high cycles of each gate over one switching period.
    task automatic meas(output int hp, output int hn, output int first);
        hp = 0; hn = 0; first = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (i == 0) first = gp | gn;
            hp += gp;
            hn += gn;
        end
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Produce an edge to 'lvl', wait so the timer reads w-1, then enable.
    task automatic start_at(input logic lvl, input int w);
        @(negedge clk);
        if (zc == lvl) begin
            zc = ~lvl;
            @(negedge clk);
        end
        zc = lvl;
        repeat (w) @(negedge clk);
        en = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 gate_pos in reset", gp, 0);
        chk("R1 gate_neg in reset", gn, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gates after reset", gp | gn, 0);
    endtask

    task automatic t_full_cycle();
        int hp, hn, f;
        start_at(1'b0, 1);
        for (int j = 0; j < HS; j++) begin
            meas(hp, hn, f);
            chk($sformatf("R3 pos step %0d width", j), hp, exp_duty(j));
            chk("R4 neg gate idle in pos half", hn, 0);
            if (j == 0) chk("R2 pulse starts at period start", f, 1);
        end
        meas(hp, hn, f);
        chk("R7 flip to neg half step 0", hn, exp_duty(0));
        chk("R4 pos gate idle in neg half", hp, 0);
        meas(hp, hn, f);
        chk("R7 neg half step 1", hn, exp_duty(1));
        stop_run();
    endtask

    task automatic t_resume();
        int hp, hn, f;
        start_at(1'b0, 1 + 2 * PER + 5);
        meas(hp, hn, f);
        chk("R6 resume pos step 2", hp, exp_duty(2));
        stop_run();
        start_at(1'b0, 1 + 6 * PER + 9);
        meas(hp, hn, f);
        chk("R6 resume pos step 6 mirrored", hp, exp_duty(6));
        meas(hp, hn, f);
        chk("R7 step 7 follows", hp, exp_duty(7));
        stop_run();
        start_at(1'b1, 1 + PER + 3);
        meas(hp, hn, f);
        chk("R5 R6 rising edge resume neg step 1", hn, exp_duty(1));
        chk("R4 pos idle on neg resume", hp, 0);
        stop_run();
        start_at(1'b0, 12 * PER);
        meas(hp, hn, f);
        chk("R5 R6 saturated timer last step", hp, exp_duty(HS - 1));
        meas(hp, hn, f);
        chk("R7 saturated start flips to neg", hn, exp_duty(0));
        stop_run();
    endtask

    task automatic t_disable();
        int hp, hn, f;
        start_at(1'b0, 1 + 3 * PER);
        meas(hp, hn, f);
        chk("R11 running before disable", hp, exp_duty(3));
        en = 1'b0;
        meas(hp, hn, f);
        chk("R11 gates low while disabled", hp + hn, 0);
    endtask

    task automatic t_runt();
        int hp, hn, f;
        start_at(1'b0, 1 + PER);
        repeat (3) @(negedge clk);
        zc = 1'b1;
        trim = 2'b11;
        repeat (PER - 3) @(negedge clk);
        trim = 2'b00;
        meas(hp, hn, f);
        chk("R8 width unchanged after mid-run zc edge", hp, exp_duty(2));
        stop_run();
    endtask

    task automatic t_trim(input logic [1:0] tv);
        int hp, hn, f;
        trim = tv;
        start_at(1'b0, 1);
        for (int k = 0; k < 2 * HS; k++) meas(hp, hn, f);
        meas(hp, hn, f);
        if (tv == 2'b01) begin
            chk("R9 advance starts pos at step 1", hp, exp_duty(1));
        end else if (tv == 2'b11) begin
            chk("R10 retard repeats last neg step", hn, exp_duty(HS - 1));
            chk("R10 retard keeps pos idle", hp, 0);
            meas(hp, hn, f);
            chk("R10 pos half follows at step 0", hp, exp_duty(0));
        end else begin
            chk("R10 zero trim normal wrap", hp, exp_duty(0));
        end
        stop_run();
        trim = 2'b00;
    endtask

    initial begin
        t_reset();
        t_full_cycle();
        t_resume();
        t_disable();
        t_runt();
        t_trim(2'b01);
        t_trim(2'b11);
        t_trim(2'b00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule